// File: doc/BRIEF.md
# Dithered PWM channel

A single pulse-width modulation channel with 14 bits of duty resolution. The duty word comes as an 8-bit coarse value and a 6-bit fine value, each written by the host into its own register. One full period is split into 64 sub-periods of 256 resolution ticks each. At the start of every sub-period the output is high for as many ticks as the coarse value says. A fixed subset of sub-periods, chosen by the fine value, gets one extra high tick. The average duty therefore moves in steps of 1/16384 of the period, while the visible ripple stays at the sub-period rate.

The host values do not act on the output directly. Each one is copied into an internal latch. The coarse latch is refreshed at every sub-period boundary and the fine latch only at a full-period boundary. While the channel is stopped, both latches track their registers. A readback port returns the latched fine value together with a flag showing that a newer fine value is still waiting. A resolution-tick enable paces the counters. Control inputs gate the output, start and stop the counting, and pick which of two output pins carries the waveform.

Top module: `dither_pwm`

## Requirements
- R1: After reset the coarse and fine registers, both latches and the pending flag are zero: `fine_rd_o` reads 00h and both pins are low.
- R2: While running, each sub-period spans 256 tick enables and a full period spans 64 sub-periods. The output is high from tick 0 of the sub-period for H ticks and low for the rest, where H is the latched coarse value plus the extra tick of R3.
- R3: Sub-period m (0..63) gets one extra tick when the fine bit assigned to m is 1. The assignment is: fine bit 5 for odd m, bit 4 for m mod 4 = 2, bit 3 for m mod 8 = 4, bit 2 for m mod 16 = 8, bit 1 for m = 16 and 48, and bit 0 for m = 32. Sub-period 0 is never lengthened.
- R4: While running, a coarse write reaches the output only from the next sub-period boundary on. The sub-period in progress keeps its old high time.
- R5: While running, a fine write reaches the output only from the next full-period boundary on. While `run_i` is 0, both latches load their registers on every clock.
- R6: `fine_rd_o[5:0]` is the latched fine value and `fine_rd_o[6]` is 0. `fine_rd_o[7]` is 1 from the clock after a fine write until the clock after the write reaches the latch.
- R7: Both pins are low whenever `en_i` or `run_i` is 0. While `run_i` is 0, the tick and sub-period counters are held at zero, so a new run starts at tick 0 of sub-period 0.
- R8: With `pin_sel_i` = 0 the waveform appears on `pwm_a_o` and `pwm_b_o` stays low. With `pin_sel_i` = 1 the roles swap.
- R9: The counters advance only on clocks where `tick_i` is 1. With `tick_i` held at 0, the output holds its level.
- R10: A high time of 256 (coarse FFh plus an extra tick) keeps the output high for the whole sub-period. Coarse FFh without an extra tick leaves the last tick low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Resolution-tick enable, one clock wide |
| wr_coarse_i | input | 1 | Write strobe for the coarse register |
| wr_fine_i | input | 1 | Write strobe for the fine register |
| wdata_i | input | 8 | Write data; the fine register takes bits 5:0 |
| en_i | input | 1 | Output enable |
| run_i | input | 1 | Run control; 0 stops and clears the counters |
| pin_sel_i | input | 1 | Output pin select |
| fine_rd_o | output | 8 | Pending flag in bit 7, latched fine value in bits 5:0 |
| pwm_a_o | output | 1 | Output pin A |
| pwm_b_o | output | 1 | Output pin B |

## Verification
The hardest situation to reach is a fine write that is still waiting while the period keeps running. It must show up in the readback flag but not in the waveform until 64 sub-periods later. The bench starts a run and writes a new coarse value partway through sub-period 0, then a new fine value in sub-period 1. It then measures the high time of every sub-period through the rest of that period and into the next. It reads the pending flag on both sides of the period boundary. A table of coarse, fine and pin-select vectors covers the R3 spreading pattern. That table includes the full-high and one-short-of-full cases.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int unsigned COARSE_W = 8;
  localparam int unsigned FINE_W   = 6;

  typedef struct packed {
    logic sub_end;
    logic period_end;
  } dpwm_bnd_t;
endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
  import dpwm_pkg::*;
#(
  parameter int unsigned TICK_W = COARSE_W,
  parameter int unsigned SUB_W  = FINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  output logic [TICK_W-1:0] tick_cnt_o,
  output logic [SUB_W-1:0]  sub_cnt_o,
  output dpwm_bnd_t         bnd_o
);
  logic [TICK_W-1:0] tick_q;
  logic [SUB_W-1:0]  sub_q;
  logic              last_tick;

  assign last_tick = (tick_q == {TICK_W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      sub_q  <= '0;
    end else if (!run_i) begin
      tick_q <= '0;
      sub_q  <= '0;
    end else if (tick_i) begin
      tick_q <= tick_q + 1'b1;
      if (last_tick) sub_q <= sub_q + 1'b1;
    end
  end

  assign bnd_o.sub_end    = run_i & tick_i & last_tick;
  assign bnd_o.period_end = run_i & tick_i & last_tick & (sub_q == {SUB_W{1'b1}});
  assign tick_cnt_o       = tick_q;
  assign sub_cnt_o        = sub_q;
endmodule

// File: rtl/dpwm_regs.sv
module dpwm_regs
  import dpwm_pkg::*;
#(
  parameter int unsigned DW = COARSE_W,
  parameter int unsigned FW = FINE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_coarse_i,
  input  logic          wr_fine_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          run_i,
  input  dpwm_bnd_t     bnd_i,
  output logic [DW-1:0] coarse_lat_o,
  output logic [FW-1:0] fine_lat_o,
  output logic          pending_o
);
  logic [DW-1:0] coarse_q, coarse_lat_q;
  logic [FW-1:0] fine_q, fine_lat_q;
  logic          pend_q;
  logic          ld_coarse, ld_fine;

  // stopped channel: latches follow registers
  assign ld_coarse = ~run_i | bnd_i.sub_end;
  assign ld_fine   = ~run_i | bnd_i.period_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_q <= '0;
      fine_q   <= '0;
    end else begin
      if (wr_coarse_i) coarse_q <= wdata_i;
      if (wr_fine_i)   fine_q   <= wdata_i[FW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coarse_lat_q <= '0;
      fine_lat_q   <= '0;
      pend_q       <= 1'b0;
    end else begin
      if (ld_coarse) coarse_lat_q <= coarse_q;
      if (ld_fine)   fine_lat_q   <= fine_q;
      // write in the load cycle stays pending for the next load
      if (wr_fine_i)    pend_q <= 1'b1;
      else if (ld_fine) pend_q <= 1'b0;
    end
  end

  assign coarse_lat_o = coarse_lat_q;
  assign fine_lat_o   = fine_lat_q;
  assign pending_o    = pend_q;
endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither
  import dpwm_pkg::*;
#(
  parameter int unsigned FW = FINE_W
) (
  input  logic [FW-1:0] sub_idx_i,
  input  logic [FW-1:0] fine_i,
  output logic          extra_o
);
  logic [FW-1:0] hit;

  // fine bit k owns the sub-periods whose lowest set index bit is FW-1-k
  for (genvar k = 0; k < FW; k++) begin : g_bit
    localparam int unsigned P = FW - 1 - k;
    if (P == 0) begin : g_lsb
      assign hit[k] = sub_idx_i[0];
    end else begin : g_upper
      assign hit[k] = sub_idx_i[P] & ~(|sub_idx_i[P-1:0]);
    end
  end

  assign extra_o = |(hit & fine_i);
endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import dpwm_pkg::*;
#(
  parameter int unsigned DW = COARSE_W,
  parameter int unsigned FW = FINE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_coarse_i,
  input  logic          wr_fine_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          en_i,
  input  logic          run_i,
  input  logic          pin_sel_i,
  output logic [DW-1:0] fine_rd_o,
  output logic          pwm_a_o,
  output logic          pwm_b_o
);
  localparam int unsigned PADW = DW - FW - 1;

  logic [DW-1:0] tick_cnt;
  logic [FW-1:0] sub_cnt;
  dpwm_bnd_t     bnd;
  logic [DW-1:0] coarse_lat;
  logic [FW-1:0] fine_lat;
  logic          pending;
  logic          extra;
  logic [DW:0]   high_len;
  logic          wave;

  dpwm_timebase #(.TICK_W(DW), .SUB_W(FW)) i_timebase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .tick_i     (tick_i),
    .tick_cnt_o (tick_cnt),
    .sub_cnt_o  (sub_cnt),
    .bnd_o      (bnd)
  );

  dpwm_regs #(.DW(DW), .FW(FW)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_coarse_i  (wr_coarse_i),
    .wr_fine_i    (wr_fine_i),
    .wdata_i      (wdata_i),
    .run_i        (run_i),
    .bnd_i        (bnd),
    .coarse_lat_o (coarse_lat),
    .fine_lat_o   (fine_lat),
    .pending_o    (pending)
  );

  dpwm_dither #(.FW(FW)) i_dither (
    .sub_idx_i (sub_cnt),
    .fine_i    (fine_lat),
    .extra_o   (extra)
  );

  assign high_len = {1'b0, coarse_lat} + {{DW{1'b0}}, extra};
  assign wave     = run_i & en_i & ({1'b0, tick_cnt} < high_len);

  assign pwm_a_o = wave & ~pin_sel_i;
  assign pwm_b_o = wave &  pin_sel_i;

  if (PADW > 0) begin : g_pad
    assign fine_rd_o = {pending, {PADW{1'b0}}, fine_lat};
  end else begin : g_nopad
    assign fine_rd_o = {pending, fine_lat};
  end
endmodule

// File: rtl/dither_pwm_chk.sv
module dither_pwm_chk #(
  parameter int unsigned DW = 8,
  parameter int unsigned FW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          en_i,
  input logic          run_i,
  input logic [DW-1:0] fine_rd_i,
  input logic          pwm_a_i,
  input logic          pwm_b_i,
  input logic [DW-1:0] tick_cnt_i,
  input logic [FW-1:0] sub_cnt_i,
  input logic [DW-1:0] coarse_lat_i
);
  logic period_last;
  assign period_last = tick_i && (tick_cnt_i == {DW{1'b1}}) && (sub_cnt_i == {FW{1'b1}});

  AST_PINS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwm_a_i && pwm_b_i)); // R8

  AST_IDLE_PINS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && en_i) |-> !pwm_a_i && !pwm_b_i); // R7

  AST_STOP_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (tick_cnt_i == '0) && (sub_cnt_i == '0)); // R7

  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(tick_cnt_i) && $stable(sub_cnt_i)); // R9

  AST_SUB_START_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && en_i && tick_cnt_i == '0 && coarse_lat_i != '0) |-> (pwm_a_i || pwm_b_i)); // R2

  AST_FINE_HELD_MID_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !period_last) |=> $stable(fine_rd_i[FW-1:0])); // R5

  AST_RD_GAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_rd_i[DW-2:FW] == '0); // R6
endmodule

bind dither_pwm dither_pwm_chk #(.DW(DW), .FW(FW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .en_i         (en_i),
  .run_i        (run_i),
  .fine_rd_i    (fine_rd_o),
  .pwm_a_i      (pwm_a_o),
  .pwm_b_i      (pwm_b_o),
  .tick_cnt_i   (tick_cnt),
  .sub_cnt_i    (sub_cnt),
  .coarse_lat_i (coarse_lat)
);

// File: tb/test_dither_pwm.sv
`timescale 1ns/1ps
module test_dither_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       wr_c = 1'b0;
  logic       wr_f = 1'b0;
  logic [7:0] wdata = '0;
  logic       en = 1'b0;
  logic       run = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] fine_rd;
  logic       pwm_a, pwm_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dither_pwm i_dither_pwm (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick),
    .wr_coarse_i (wr_c), .wr_fine_i (wr_f), .wdata_i (wdata),
    .en_i (en), .run_i (run), .pin_sel_i (sel),
    .fine_rd_o (fine_rd), .pwm_a_o (pwm_a), .pwm_b_o (pwm_b)
  );

  // [15] pin select, [13:8] fine, [7:0] coarse
  localparam int NV = 7;
  localparam logic [15:0] VEC [NV] = '{
    16'h0503, 16'h8000, 16'h3FFF, 16'h80FF, 16'h2080, 16'hAA7F, 16'h8100
  };

  function automatic int extra_of(input logic [5:0] f, input int m);
    return ((f[0] && m == 32) || (f[1] && (m == 16 || m == 48)) ||
            (f[2] && m % 16 == 8) || (f[3] && m % 8 == 4) ||
            (f[4] && m % 4 == 2) || (f[5] && m % 2 == 1)) ? 1 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write_reg(input bit fine, input logic [7:0] d);
    wdata = d; wr_c = !fine; wr_f = fine;
    step();
    wr_c = 1'b0; wr_f = 1'b0;
  endtask

  // one sub-period measured on the selected pin, both pins checked each tick
  task automatic measure_sub(input int exp_hi, output int hi, output int bad);
    hi = 0; bad = 0;
    for (int t = 0; t < 256; t++) begin
      @(negedge clk);
      if ((sel ? pwm_b : pwm_a) != (t < exp_hi)) bad++;
      if ((sel ? pwm_a : pwm_b) != 1'b0) bad++;
      if (sel ? pwm_b : pwm_a) hi++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, bad;
    // R1 reset state
    #3;
    check("R1 rd in reset", fine_rd, 0);
    check("R1 pins in reset", {pwm_a, pwm_b}, 0);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 rd after reset", fine_rd, 0);
    check("R1 pins after reset", {pwm_a, pwm_b}, 0);

    // R2 R3 R8 R10 vector table
    for (int v = 0; v < NV; v++) begin
      run = 1'b0; en = 1'b1; sel = VEC[v][15];
      write_reg(1'b0, VEC[v][7:0]);
      write_reg(1'b1, {2'b00, VEC[v][13:8]});
      step();
      run = 1'b1;
      for (int m = 0; m < 64; m++) begin
        int e;
        e = int'(VEC[v][7:0]) + extra_of(VEC[v][13:8], m);
        measure_sub(e, hi, bad);
        check($sformatf("R2 R3 R8 R10 vec%0d sub%0d high", v, m), hi, e);
        check($sformatf("R2 R8 vec%0d sub%0d shape", v, m), bad, 0);
      end
      step();
      run = 1'b0;
    end

    // R4 R5 R6 transfer boundaries
    run = 1'b0; en = 1'b1; sel = 1'b0;
    write_reg(1'b0, 8'h02);
    write_reg(1'b1, 8'h00);
    step();
    run = 1'b1;
    hi = 0;
    for (int t = 0; t < 256; t++) begin
      @(negedge clk);
      if (pwm_a) hi++;
      if (t == 100) begin wdata = 8'h05; wr_c = 1'b1; end
      if (t == 101) wr_c = 1'b0;
    end
    check("R4 old coarse kept in current sub", hi, 2);
    hi = 0;
    for (int t = 0; t < 256; t++) begin
      @(negedge clk);
      if (pwm_a) hi++;
      if (t == 50) begin wdata = 8'h3F; wr_f = 1'b1; end
      if (t == 51) begin
        wr_f = 1'b0;
        check("R6 pending with old fine", fine_rd, 8'h80);
      end
    end
    check("R4 new coarse next sub", hi, 5);
    measure_sub(5, hi, bad);
    check("R5 fine not applied mid period", hi, 5);
    for (int m = 3; m < 64; m++) measure_sub(0, hi, bad);
    measure_sub(5, hi, bad);
    check("R6 flag clear after boundary", fine_rd, 8'h3F);
    measure_sub(6, hi, bad);
    check("R5 odd sub after period", hi, 6);
    measure_sub(6, hi, bad);
    check("R5 sub2 after period", hi, 6);
    step();
    run = 1'b0;
    step();
    check("R5 R6 stopped flag state", fine_rd, 8'h3F);
    write_reg(1'b1, 8'h15);
    check("R6 pending right after write", fine_rd[7], 1);
    step();
    check("R5 stopped latch follows", fine_rd, 8'h15);

    // R7 enable and run gating
    write_reg(1'b0, 8'h03);
    write_reg(1'b1, 8'h00);
    en = 1'b0; run = 1'b1;
    hi = 0;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      if (pwm_a || pwm_b) hi++;
    end
    check("R7 disabled pins low", hi, 0);
    step();
    run = 1'b0; en = 1'b1;
    @(negedge clk);
    check("R7 stopped pins low", {pwm_a, pwm_b}, 0);

    // R9 tick enable gating, R7 restart at tick 0
    tick = 1'b0;
    step();
    run = 1'b1;
    hi = 0;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (pwm_a) hi++;
    end
    check("R7 R9 frozen at tick 0 high", hi, 20);
    step();
    tick = 1'b1;
    step();
    step();
    tick = 1'b0;
    @(negedge clk);
    check("R9 two ticks still high", pwm_a, 1);
    step();
    tick = 1'b1;
    step();
    tick = 1'b0;
    hi = 0;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      if (pwm_a) hi++;
    end
    check("R9 third tick ends high", hi, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule